// File: doc/BRIEF.md
# Register-to-Register Execute Unit

This block is a single-cycle execute stage. It holds eight 16-bit general-purpose registers and four condition flags (negative, zero, overflow, carry). Each cycle with the valid strobe high it runs one decoded operation. The operation takes its operands from the register file and writes its result back at the next rising clock edge.

There are two operation forms. The in-place form shifts the destination register by an amount taken from another register. The three-register form combines two source registers with add-with-carry, subtract, AND, OR or XOR, and writes the result to a third register. Naming register 0 as the destination discards the result but still updates the flags, so register 0 serves as a compare-only target. A load-immediate operation writes a register from a data input and gives the register file a starting state. A combinational read port shows any register's contents.

Top module: `reu_core`

## Requirements
- R1: While rst_ni is low, every register reads 0 on the read port and all four flags are 0.
- R2: Register 0 used as a source supplies the value 0, and the read port returns 0 when it selects register 0.
- R3: An operation whose destination is register 0 writes no register but updates the flags from its result.
- R4: Add-with-carry (op_i = 3'b010) writes rs1 + rs2 + C to rd. C is set to the carry out of bit 15, and V is set when both operands share a sign that differs from the sign of the result.
- R5: Subtract (op_i = 3'b011) writes rs1 - rs2 to rd. C is set to the borrow (rs1 < rs2 unsigned), and V is set when the operands differ in sign and the result's sign differs from rs1's.
- R6: AND, OR and XOR (op_i = 3'b100, 3'b101, 3'b110) write the bitwise result of rs1 and rs2 to rd, clear V, and leave C unchanged.
- R7: Shift left (op_i = 3'b000) writes rd shifted left by the value in register rs2. C is set to the last bit shifted out, and V is cleared.
- R8: Shift right (op_i = 3'b001) writes rd logically shifted right by the value in register rs2. C is set to the last bit shifted out, and V is cleared.
- R9: A shift amount of 0 leaves the operand and C unchanged. An amount of 16 gives 0 with C set to the bit moved out last (bit 0 for a left shift, bit 15 for a right shift). An amount above 16 gives 0 with C cleared.
- R10: For every flag-updating operation, N equals bit 15 of the result and Z is set exactly when the 16-bit result is 0.
- R11: With valid_i low, no register and no flag changes.
- R12: Load-immediate (op_i = 3'b111) writes imm_i to rd and leaves all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Execute the presented operation at this edge |
| op_i | input | 3 | Decoded operation code |
| rd_i | input | 3 | Destination register; for shifts, also the operand |
| rs1_i | input | 3 | First source register (three-register form) |
| rs2_i | input | 3 | Second source register, or the register holding the shift amount |
| imm_i | input | 16 | Immediate data for load-immediate |
| rdbk_sel_i | input | 3 | Read port register select |
| rdbk_data_o | output | 16 | Read port data |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_c_o | output | 1 | Carry / borrow flag |

## Verification
The hardest cases to reach are those that depend on the incoming carry: add-with-carry with C set, a logic operation that must keep a C of 1, and shifts whose C result must differ from the C before them. The stimulus table orders operations so that C is first set to the opposite of the expected outcome, using a borrowing subtract, a right shift that drops a 1, or a subtract that cannot borrow. Only then does the operation under test run. The shift amounts 0, 1, 4, 16, 17 and a large value are loaded through load-immediate, so every branch of the shift range is covered.

// File: rtl/reu_pkg.sv
package reu_pkg;
  typedef enum logic [2:0] {
    OP_LSL = 3'd0,
    OP_LSR = 3'd1,
    OP_ADC = 3'd2,
    OP_SUB = 3'd3,
    OP_AND = 3'd4,
    OP_OR  = 3'd5,
    OP_XOR = 3'd6,
    OP_LDI = 3'd7
  } op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;
endpackage

// File: rtl/reu_regfile.sv
module reu_regfile #(
  parameter int DATA_W = 16,
  parameter int NREG   = 8,
  localparam int AW    = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [AW-1:0]     raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o,
  input  logic [AW-1:0]     raddr_c_i,
  output logic [DATA_W-1:0] rdata_c_o
);
  logic [NREG-1:0][DATA_W-1:0] words;

  for (genvar g = 0; g < NREG; g++) begin : g_word
    if (g == 0) begin : g_zero
      // register 0 has no storage
      assign words[g] = '0;
    end else begin : g_store
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                q <= '0;
        else if (we_i && (waddr_i == AW'(g)))       q <= wdata_i;
      end
      assign words[g] = q;
    end
  end

  assign rdata_a_o = words[raddr_a_i];
  assign rdata_b_o = words[raddr_b_i];
  assign rdata_c_o = words[raddr_c_i];
endmodule

// File: rtl/reu_shifter.sv
module reu_shifter #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] amt_i,
  input  logic              left_i,
  input  logic              c_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o
);
  localparam int SW = $clog2(DATA_W) + 1;
  localparam logic [DATA_W-1:0] LIM = DATA_W'(DATA_W);

  logic [DATA_W:0]  ext;
  logic [SW-1:0]    sh;

  always_comb begin
    ext   = '0;
    sh    = amt_i[SW-1:0];
    res_o = a_i;
    c_o   = c_i;
    if (amt_i == '0) begin
      res_o = a_i;
      c_o   = c_i;
    end else if (amt_i > LIM) begin
      res_o = '0;
      c_o   = 1'b0;
    end else if (left_i) begin
      // extra top bit catches the last bit shifted out
      ext   = {1'b0, a_i} << sh;
      res_o = ext[DATA_W-1:0];
      c_o   = ext[DATA_W];
    end else begin
      ext   = {a_i, 1'b0} >> sh;
      res_o = ext[DATA_W:1];
      c_o   = ext[0];
    end
  end
endmodule

// File: rtl/reu_alu.sv
module reu_alu
  import reu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              c_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o,
  output logic              v_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0] wide;

  always_comb begin
    wide  = '0;
    res_o = '0;
    c_o   = c_i;
    v_o   = 1'b0;
    unique case (op_i)
      OP_ADC: begin
        wide  = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, c_i};
        res_o = wide[DATA_W-1:0];
        c_o   = wide[DATA_W];
        v_o   = (a_i[MSB] == b_i[MSB]) && (res_o[MSB] != a_i[MSB]);
      end
      OP_SUB: begin
        wide  = {1'b0, a_i} - {1'b0, b_i};
        res_o = wide[DATA_W-1:0];
        c_o   = wide[DATA_W];
        v_o   = (a_i[MSB] != b_i[MSB]) && (res_o[MSB] != a_i[MSB]);
      end
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/reu_core.sv
module reu_core
  import reu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NREG   = 8,
  localparam int AW    = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [AW-1:0]     rd_i,
  input  logic [AW-1:0]     rs1_i,
  input  logic [AW-1:0]     rs2_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic [AW-1:0]     rdbk_sel_i,
  output logic [DATA_W-1:0] rdbk_data_o,
  output logic              flag_n_o,
  output logic              flag_z_o,
  output logic              flag_v_o,
  output logic              flag_c_o
);
  op_e               op;
  logic              is_shift;
  logic [AW-1:0]     src_a_sel;
  logic [DATA_W-1:0] src_a, src_b;
  logic [DATA_W-1:0] alu_res, sh_res, result;
  logic              alu_c, alu_v, sh_c;
  logic              we;
  flags_t            flags_q, flags_d;

  assign op        = op_e'(op_i);
  assign is_shift  = (op == OP_LSL) || (op == OP_LSR);
  // the in-place shift reads its operand from the destination
  assign src_a_sel = is_shift ? rd_i : rs1_i;
  assign we        = valid_i && (rd_i != '0);

  reu_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we),
    .waddr_i   (rd_i),
    .wdata_i   (result),
    .raddr_a_i (src_a_sel),
    .rdata_a_o (src_a),
    .raddr_b_i (rs2_i),
    .rdata_b_o (src_b),
    .raddr_c_i (rdbk_sel_i),
    .rdata_c_o (rdbk_data_o)
  );

  reu_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i  (op),
    .a_i   (src_a),
    .b_i   (src_b),
    .c_i   (flags_q.c),
    .res_o (alu_res),
    .c_o   (alu_c),
    .v_o   (alu_v)
  );

  reu_shifter #(.DATA_W(DATA_W)) u_sh (
    .a_i    (src_a),
    .amt_i  (src_b),
    .left_i (op == OP_LSL),
    .c_i    (flags_q.c),
    .res_o  (sh_res),
    .c_o    (sh_c)
  );

  always_comb begin
    if (op == OP_LDI)  result = imm_i;
    else if (is_shift) result = sh_res;
    else               result = alu_res;
  end

  always_comb begin
    flags_d.n = result[DATA_W-1];
    flags_d.z = (result == '0);
    flags_d.v = is_shift ? 1'b0 : alu_v;
    flags_d.c = is_shift ? sh_c : alu_c;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         flags_q <= '0;
    else if (valid_i && (op != OP_LDI))  flags_q <= flags_d;
  end

  assign flag_n_o = flags_q.n;
  assign flag_z_o = flags_q.z;
  assign flag_v_o = flags_q.v;
  assign flag_c_o = flags_q.c;
endmodule

// File: rtl/reu_core_chk.sv
module reu_core_chk #(
  parameter int DATA_W = 16,
  parameter int AW     = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        op_i,
  input logic [AW-1:0]     rdbk_sel_i,
  input logic [DATA_W-1:0] rdbk_data_o,
  input logic              flag_n_o,
  input logic              flag_z_o,
  input logic              flag_v_o,
  input logic              flag_c_o
);
  logic [3:0] flags;
  assign flags = {flag_n_o, flag_z_o, flag_v_o, flag_c_o};

  // R11
  flags_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(flags));

  // R11
  regs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(rdbk_sel_i) -> $stable(rdbk_data_o)));

  // R2
  r0_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdbk_sel_i == '0) |-> (rdbk_data_o == '0));

  // R6
  logic_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i inside {3'd4, 3'd5, 3'd6})) |=>
      (!flag_v_o && (flag_c_o == $past(flag_c_o))));

  // R12
  ldi_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 3'd7)) |=> $stable(flags));

  // R10
  nz_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flag_n_o && flag_z_o));
endmodule

bind reu_core reu_core_chk #(.DATA_W(DATA_W), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .op_i        (op_i),
  .rdbk_sel_i  (rdbk_sel_i),
  .rdbk_data_o (rdbk_data_o),
  .flag_n_o    (flag_n_o),
  .flag_z_o    (flag_z_o),
  .flag_v_o    (flag_v_o),
  .flag_c_o    (flag_c_o)
);

// File: tb/reu_core_tb.sv
`timescale 1ns/1ps
module reu_core_tb;
  localparam logic [2:0] LSL = 3'd0, LSR = 3'd1, ADC = 3'd2, SUB = 3'd3,
                         AND = 3'd4, ORR = 3'd5, XOR = 3'd6, LDI = 3'd7;
  localparam int NV = 48;

  // {req, op, rd, rs1, rs2, imm, expected rd, expected {n,z,v,c}}
  localparam logic [51:0] VEC [NV] = '{
    {4'd12, LDI, 3'd1, 3'd0, 3'd0, 16'h8000, 16'h8000, 4'b0000}, // R12
    {4'd12, LDI, 3'd2, 3'd0, 3'd0, 16'h8000, 16'h8000, 4'b0000}, // R12
    {4'd4,  ADC, 3'd3, 3'd1, 3'd2, 16'h0000, 16'h0000, 4'b0111}, // R4 carry+overflow
    {4'd12, LDI, 3'd4, 3'd0, 3'd0, 16'h0001, 16'h0001, 4'b0111}, // R12 flags kept
    {4'd2,  ADC, 3'd5, 3'd4, 3'd0, 16'h0000, 16'h0002, 4'b0000}, // R2 R0 source, C in
    {4'd5,  SUB, 3'd6, 3'd4, 3'd5, 16'h0000, 16'hFFFF, 4'b1001}, // R5 borrow
    {4'd4,  ADC, 3'd7, 3'd4, 3'd4, 16'h0000, 16'h0003, 4'b0000}, // R4 carry in
    {4'd12, LDI, 3'd1, 3'd0, 3'd0, 16'h7FFF, 16'h7FFF, 4'b0000}, // R12
    {4'd4,  ADC, 3'd2, 3'd1, 3'd4, 16'h0000, 16'h8000, 4'b1010}, // R4 pos overflow
    {4'd5,  SUB, 3'd3, 3'd2, 3'd4, 16'h0000, 16'h7FFF, 4'b0010}, // R5 overflow
    {4'd3,  SUB, 3'd0, 3'd4, 3'd4, 16'h0000, 16'h0000, 4'b0100}, // R3 compare equal
    {4'd3,  SUB, 3'd0, 3'd0, 3'd4, 16'h0000, 16'h0000, 4'b1001}, // R3 compare borrow
    {4'd12, LDI, 3'd1, 3'd0, 3'd0, 16'hF0F0, 16'hF0F0, 4'b1001}, // R12
    {4'd12, LDI, 3'd2, 3'd0, 3'd0, 16'h0FF0, 16'h0FF0, 4'b1001}, // R12
    {4'd6,  AND, 3'd3, 3'd1, 3'd2, 16'h0000, 16'h00F0, 4'b0001}, // R6 C kept
    {4'd6,  ORR, 3'd5, 3'd1, 3'd2, 16'h0000, 16'hFFF0, 4'b1001}, // R6
    {4'd6,  XOR, 3'd6, 3'd1, 3'd2, 16'h0000, 16'hFF00, 4'b1001}, // R6
    {4'd3,  XOR, 3'd0, 3'd1, 3'd1, 16'h0000, 16'h0000, 4'b0101}, // R3
    {4'd2,  AND, 3'd7, 3'd1, 3'd0, 16'h0000, 16'h0000, 4'b0101}, // R2
    {4'd12, LDI, 3'd1, 3'd0, 3'd0, 16'h8001, 16'h8001, 4'b0101}, // R12
    {4'd12, LDI, 3'd2, 3'd0, 3'd0, 16'h0001, 16'h0001, 4'b0101}, // R12
    {4'd7,  LSL, 3'd1, 3'd0, 3'd2, 16'h0000, 16'h0002, 4'b0001}, // R7
    {4'd8,  LSR, 3'd1, 3'd0, 3'd2, 16'h0000, 16'h0001, 4'b0000}, // R8
    {4'd12, LDI, 3'd4, 3'd0, 3'd0, 16'h0003, 16'h0003, 4'b0000}, // R12
    {4'd8,  LSR, 3'd4, 3'd0, 3'd2, 16'h0000, 16'h0001, 4'b0001}, // R8 C from bit 0
    {4'd12, LDI, 3'd3, 3'd0, 3'd0, 16'h0000, 16'h0000, 4'b0001}, // R12
    {4'd9,  LSL, 3'd4, 3'd0, 3'd3, 16'h0000, 16'h0001, 4'b0001}, // R9 amount 0
    {4'd12, LDI, 3'd5, 3'd0, 3'd0, 16'h0010, 16'h0010, 4'b0001}, // R12
    {4'd12, LDI, 3'd6, 3'd0, 3'd0, 16'h0001, 16'h0001, 4'b0001}, // R12
    {4'd5,  SUB, 3'd7, 3'd4, 3'd0, 16'h0000, 16'h0001, 4'b0000}, // R5 clear C
    {4'd9,  LSL, 3'd6, 3'd0, 3'd5, 16'h0000, 16'h0000, 4'b0101}, // R9 amount 16
    {4'd12, LDI, 3'd6, 3'd0, 3'd0, 16'h8000, 16'h8000, 4'b0101}, // R12
    {4'd5,  SUB, 3'd7, 3'd4, 3'd0, 16'h0000, 16'h0001, 4'b0000}, // R5 clear C
    {4'd9,  LSR, 3'd6, 3'd0, 3'd5, 16'h0000, 16'h0000, 4'b0101}, // R9 amount 16
    {4'd12, LDI, 3'd5, 3'd0, 3'd0, 16'h0011, 16'h0011, 4'b0101}, // R12
    {4'd12, LDI, 3'd6, 3'd0, 3'd0, 16'hFFFF, 16'hFFFF, 4'b0101}, // R12
    {4'd9,  LSL, 3'd6, 3'd0, 3'd5, 16'h0000, 16'h0000, 4'b0100}, // R9 amount 17
    {4'd12, LDI, 3'd6, 3'd0, 3'd0, 16'hFFFF, 16'hFFFF, 4'b0100}, // R12
    {4'd8,  LSR, 3'd6, 3'd0, 3'd2, 16'h0000, 16'h7FFF, 4'b0001}, // R8
    {4'd9,  LSR, 3'd6, 3'd0, 3'd5, 16'h0000, 16'h0000, 4'b0100}, // R9 amount 17
    {4'd12, LDI, 3'd7, 3'd0, 3'd0, 16'h1234, 16'h1234, 4'b0100}, // R12
    {4'd9,  LSL, 3'd7, 3'd0, 3'd7, 16'h0000, 16'h0000, 4'b0100}, // R9 large amount
    {4'd12, LDI, 3'd1, 3'd0, 3'd0, 16'h4000, 16'h4000, 4'b0100}, // R12
    {4'd10, LSL, 3'd1, 3'd0, 3'd2, 16'h0000, 16'h8000, 4'b1000}, // R10 N from bit 15
    {4'd3,  LSR, 3'd0, 3'd0, 3'd2, 16'h0000, 16'h0000, 4'b0100}, // R3 shift to R0
    {4'd12, LDI, 3'd2, 3'd0, 3'd0, 16'h0004, 16'h0004, 4'b0100}, // R12
    {4'd12, LDI, 3'd1, 3'd0, 3'd0, 16'h00F8, 16'h00F8, 4'b0100}, // R12
    {4'd8,  LSR, 3'd1, 3'd0, 3'd2, 16'h0000, 16'h000F, 4'b0001}  // R8 amount 4
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0, rd_i = '0, rs1_i = '0, rs2_i = '0, rdbk_sel_i = '0;
  logic [15:0] imm_i = '0;
  logic [15:0] rdbk_data_o;
  logic        flag_n_o, flag_z_o, flag_v_o, flag_c_o;
  int          n_chk = 0, n_fail = 0;

  always #4 clk_i = ~clk_i;

  reu_core u_dut (.*);

  task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp,
                       input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] flags();
    return {12'h0, flag_n_o, flag_z_o, flag_v_o, flag_c_o};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk_i);
    // R1 reset state
    for (int r = 0; r < 8; r++) begin
      rdbk_sel_i = 3'(r);
      #1 check(1, rdbk_data_o, 16'h0, "reset register");
    end
    check(1, flags(), 16'h0, "reset flags");
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      {op_i, rd_i, rs1_i, rs2_i, imm_i} = VEC[i][47:20];
      valid_i = 1'b1;
      @(negedge clk_i);
      valid_i    = 1'b0;
      rdbk_sel_i = VEC[i][44:42];
      #1;
      check(int'(VEC[i][51:48]), rdbk_data_o, VEC[i][19:4], $sformatf("vector %0d data", i));
      check(int'(VEC[i][51:48]), flags(), {12'h0, VEC[i][3:0]}, $sformatf("vector %0d flags", i));
    end

    // R11: a borrowing subtract into R1 with valid low changes nothing
    @(negedge clk_i);
    {op_i, rd_i, rs1_i, rs2_i} = {SUB, 3'd1, 3'd0, 3'd1};
    valid_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rdbk_sel_i = 3'd1;
    #1 check(11, rdbk_data_o, 16'h000F, "valid low data");
    check(11, flags(), 16'h0001, "valid low flags");

    // R1 asynchronous reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1 check(1, rdbk_data_o, 16'h0, "mid-run reset R1 data");
    rdbk_sel_i = 3'd6;
    #1 check(1, rdbk_data_o, 16'h0, "mid-run reset R6 data");
    check(1, flags(), 16'h0, "mid-run reset flags");
    @(negedge clk_i);
    rst_ni = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule